// File: doc/BRIEF.md
# Cycle-Gated Performance Counter Bank

This block holds four event counters that a memory controller uses to measure its own traffic. Slot 0 counts clock cycles and nothing else. It is the timebase for the whole bank: while it is disabled, or after it has wrapped, no other slot advances. Slots 1 to 3 each pick one event code and count the cycles in which the matching bit of a per-cycle event pulse vector is high. Software reaches the bank through a small port with valid, write, address and data signals. It configures each slot through a control word and reads the counts from a separate block of value words.

When the cycle slot wraps, the whole bank freezes and a level interrupt goes high. The interrupt stays high until software restarts the cycle slot. To make the cycle slot wrap sooner, software can give it a preload byte that seeds the upper count bits whenever the slot is restarted. The two kinds of slot clear in different ways. An event slot clears when software writes 0 to its clear bit, and the hardware then sets the bit back to 1 on its own. The cycle slot clears only on a rising write of its clear bit, that is, a write of 0 followed later by a write of 1.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every control word reads 0x00000002 (only the clear bit, bit 1, is set), every value word reads 0, and `irq` is low.
- R2: Control word n is at byte address 4*n and value word n is at 0x20 + 4*n, for n = 0..3, with the low two address bits ignored. The control word fields are: bit 0 overflow flag (read only), bit 1 clear, bit 2 enable, bits 23:16 preload, bits 31:24 event code. Reads of any other address return 0.
- R3: While the cycle slot is enabled and has not overflowed, its count rises by exactly 1 every clock cycle. Its event code field ignores writes and always reads 0.
- R4: An event slot whose enable is set, while the cycle slot is running, adds 1 on each clock edge at which `events[code]` is high. A code at or above NUM_EVT never matches any pulse.
- R5: While the cycle slot is disabled, no slot advances. Enabling the cycle slot again resumes every enabled slot from its held count.
- R6: A control write with enable 0 and clear 1 stops that slot and leaves its count unchanged.
- R7: Writing 0 to an event slot's clear bit zeroes its count and overflow flag at the next edge. The clear bit reads 0 for the one cycle that follows, and then reads 1 again without any further write.
- R8: The cycle slot clears only when a write sets its clear bit while the stored bit is 0. The clear loads preload << PRELOAD_LSB into the count and drops the overflow flag. A write of 0 to that bit changes no count.
- R9: When the cycle slot wraps from all ones, its count becomes 0, its overflow flag is set, `irq` rises, and no slot in the bank advances any further.
- R10: `irq` stays high until the cycle slot's clear sequence completes, and goes low at that point.
- R11: With LEGACY_WRAP = 0, an event slot that wraps sets its overflow flag, reads 0, and ignores further pulses until it is cleared. `irq` is not raised.
- R12: With LEGACY_WRAP = 1, an event slot that wraps sets its overflow flag and keeps counting from 0.
- R13: When a clear and an increment of the same slot occur in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is active |
| events | input | NUM_EVT (64) | One pulse bit per event code, sampled on the rising edge |
| irq | output | 1 | Level interrupt: cycle slot has overflowed |

## Verification
Two collisions matter here: a clear write that lands in the same cycle as a counting pulse, and the cycle slot's wrap, which freezes the other slots in the same edge at which they would otherwise count. The first is provoked by pulsing an event slot's own code during the write that zeroes it. The check expects a count of 0 and not 1. The second is provoked by seeding the cycle slot near its top with a preload and pulsing an event slot across the wrap and afterwards. The check expects the event count unchanged, `irq` high, and every value held until the cycle slot is restarted. Two instances, one with each wrap policy, take the same stimulus so that the event-slot overflow behaviour can be compared directly.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int NUM_CTR  = 4;
    localparam int CODE_W   = 8;
    localparam int PRE_W    = 8;
    localparam int IDX_W    = $clog2(NUM_CTR);
    localparam logic [7:0] VAL_BASE = 8'h20;

    // stored configuration of one slot (overflow is kept apart as status)
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PRE_W-1:0]  preload;
        logic              en;
        logic              clr;
    } ctr_cfg_t;

    localparam ctr_cfg_t CFG_RESET = '{code: '0, preload: '0, en: 1'b0, clr: 1'b1};

    function automatic ctr_cfg_t unpack_ctl(input logic [31:0] w);
        ctr_cfg_t c;
        c.code    = w[31:24];
        c.preload = w[23:16];
        c.en      = w[2];
        c.clr     = w[1];
        return c;
    endfunction

    function automatic logic [31:0] pack_ctl(input ctr_cfg_t c, input logic ovf);
        return {c.code, c.preload, 13'd0, c.en, c.clr, ovf};
    endfunction

endpackage

// File: rtl/pcb_event_select.sv
module pcb_event_select
    import pcb_pkg::*;
#(
    parameter int NUM_EVT = 64
) (
    input  logic [NUM_EVT-1:0] events,
    input  logic [CODE_W-1:0]  code,
    output logic               hit
);
    // codes at or above NUM_EVT match nothing
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (int'(code) == i) hit = events[i];
        end
    end

endmodule

// File: rtl/pcb_counter_slot.sv
module pcb_counter_slot
    import pcb_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRELOAD_LSB = 16,
    parameter bit IS_CYCLE    = 1'b0,
    parameter bit LEGACY_WRAP = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  ctr_cfg_t         wcfg,
    input  logic             step,
    output ctr_cfg_t         cfg_q,
    output logic             ovf_q,
    output logic [CNT_W-1:0] cnt_q
);
    typedef logic [CNT_W-1:0] cnt_t;

    logic     clr_fire;
    logic     step_ok;
    cnt_t     load_val;
    ctr_cfg_t cfg_next;

    generate
        if (IS_CYCLE) begin : g_cycle
            logic unused_code;
            assign unused_code = ^wcfg.code;
            // rising write of the clear bit; reload the bias
            assign clr_fire = wr & wcfg.clr & ~cfg_q.clr;
            assign load_val = cnt_t'(wcfg.preload) << PRELOAD_LSB;
            assign step_ok  = step & ~ovf_q;
            always_comb begin
                cfg_next = cfg_q;
                if (wr) cfg_next = '{code: '0, preload: wcfg.preload, en: wcfg.en, clr: wcfg.clr};
            end
        end else begin : g_event
            assign clr_fire = wr & ~wcfg.clr;
            assign load_val = '0;
            assign step_ok  = step & (~ovf_q | LEGACY_WRAP);
            always_comb begin
                cfg_next = cfg_q;
                if (wr)              cfg_next = wcfg;
                else if (!cfg_q.clr) cfg_next.clr = 1'b1;
            end

            // R7
            clr_return_chk: assert property (@(posedge clk) disable iff (rst)
                (!cfg_q.clr && !wr) |=> cfg_q.clr);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            ovf_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            cfg_q <= cfg_next;
            if (clr_fire) begin
                cnt_q <= load_val;
                ovf_q <= 1'b0;
            end else if (step_ok) begin
                cnt_q <= cnt_q + 1'b1;
                if (&cnt_q) ovf_q <= 1'b1;
            end
        end
    end

    // R13
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_fire |=> (cnt_q == $past(load_val)) && !ovf_q);

    // R9 R11 R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr_fire) |=> ovf_q);

    generate
        if (IS_CYCLE || !LEGACY_WRAP) begin : g_hold_chk
            // R9 R11
            ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (ovf_q && !clr_fire) |=> $stable(cnt_q));
        end
    endgenerate

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRELOAD_LSB = 16,
    parameter int NUM_EVT     = 64,
    parameter bit LEGACY_WRAP = 1'b0,
    parameter int ADDR_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] events,
    output logic               irq
);
    typedef logic [CNT_W-1:0] cnt_t;

    localparam int REG_LSB = IDX_W + 2;
    localparam logic [ADDR_W-1:0] VAL_ADDR = ADDR_W'(VAL_BASE);

    ctr_cfg_t           cfg_q [NUM_CTR];
    cnt_t               cnt_q [NUM_CTR];
    logic [NUM_CTR-1:0] ovf_q;
    logic [NUM_CTR-1:0] tick;
    logic [NUM_CTR-1:0] wr_str;
    logic [IDX_W-1:0]   idx;
    logic               ctl_hit, val_hit, bank_run;
    ctr_cfg_t           wcfg;
    logic               unused_bits;

    assign idx      = bus_addr[REG_LSB-1:2];
    assign ctl_hit  = (bus_addr[ADDR_W-1:REG_LSB] == '0);
    assign val_hit  = (bus_addr[ADDR_W-1:REG_LSB] == VAL_ADDR[ADDR_W-1:REG_LSB]);
    assign wcfg     = unpack_ctl(bus_wdata);
    assign bank_run = cfg_q[0].en & ~ovf_q[0];
    assign irq      = ovf_q[0];
    assign unused_bits = ^{bus_wdata[15:3], bus_wdata[0], bus_addr[1:0]};

    always_comb begin
        for (int n = 0; n < NUM_CTR; n++) begin
            wr_str[n] = bus_valid & bus_write & ctl_hit & (int'(idx) == n);
        end
    end

    generate
        for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
            if (g == 0) begin : g_src
                assign tick[g] = cfg_q[g].en;
            end else begin : g_src
                logic hit_g;
                pcb_event_select #(.NUM_EVT(NUM_EVT)) u_sel (
                    .events (events),
                    .code   (cfg_q[g].code),
                    .hit    (hit_g)
                );
                assign tick[g] = cfg_q[g].en & bank_run & hit_g;

                // R5 R9
                frozen_chk: assert property (@(posedge clk) disable iff (rst)
                    (!bank_run && !wr_str[g]) |=> $stable(cnt_q[g]));
            end

            pcb_counter_slot #(
                .CNT_W       (CNT_W),
                .PRELOAD_LSB (PRELOAD_LSB),
                .IS_CYCLE    (g == 0),
                .LEGACY_WRAP (LEGACY_WRAP)
            ) u_slot (
                .clk   (clk),
                .rst   (rst),
                .wr    (wr_str[g]),
                .wcfg  (wcfg),
                .step  (tick[g]),
                .cfg_q (cfg_q[g]),
                .ovf_q (ovf_q[g]),
                .cnt_q (cnt_q[g])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            if (ctl_hit)      bus_rdata = pack_ctl(cfg_q[idx], ovf_q[idx]);
            else if (val_hit) bus_rdata = 32'(cnt_q[idx]);
        end
    end

    cnt_t cyc_cnt;
    assign cyc_cnt = cnt_q[0];

    // R3
    cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[0].en && !ovf_q[0] && !wr_str[0]) |=> cyc_cnt == cnt_t'($past(cyc_cnt) + 1'b1));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_str[0]) |=> irq);

    // R3
    cycle_code_chk: assert property (@(posedge clk) disable iff (rst)
        wr_str[0] |=> cfg_q[0].code == '0);

endmodule

// File: tb/tb_perf_counter_bank.sv
module tb_perf_counter_bank;

    localparam int TW  = 12;
    localparam int TPL = 4;
    localparam int TEV = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_valid = 1'b0;
    logic           bus_write = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [TEV-1:0] events = '0;
    logic [31:0]    rdata, rdata_lg;
    logic           irq, irq_lg;

    always #4 clk = ~clk;

    perf_counter_bank #(.CNT_W(TW), .PRELOAD_LSB(TPL), .NUM_EVT(TEV), .LEGACY_WRAP(1'b0), .ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .events(events), .irq(irq));

    perf_counter_bank #(.CNT_W(TW), .PRELOAD_LSB(TPL), .NUM_EVT(TEV), .LEGACY_WRAP(1'b1), .ADDR_W(8)) dut_lg (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_lg), .events(events), .irq(irq_lg));

    typedef struct packed {
        logic        is_irq;
        logic [7:0]  req;
        logic [7:0]  addr;
        logic [31:0] exp;
        logic [31:0] exp_lg;
    } item_t;

    item_t sbq[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    function automatic logic [31:0] ctl(input int code, input int pre, input bit en, input bit clr, input bit ovf);
        return {8'(code), 8'(pre), 13'd0, en, clr, ovf};
    endfunction

    // monitor: compares one queued expectation per read cycle, mid-cycle
    always @(negedge clk) begin : mon
        item_t       it;
        logic [31:0] act, act_lg;
        if (sbq.size() != 0) begin
            it = sbq.pop_front();
            if (it.is_irq) begin
                act    = {31'd0, irq};
                act_lg = {31'd0, irq_lg};
            end else begin
                act    = rdata;
                act_lg = rdata_lg;
            end
            checks++;
            if (act !== it.exp || act_lg !== it.exp_lg) begin
                errors++;
                $display("FAIL R%0d addr=%02h actual=%08h/%08h expected=%08h/%08h",
                         it.req, it.addr, act, act_lg, it.exp, it.exp_lg);
            end
        end
    end

    task automatic op_wr(input logic [7:0] a, input logic [31:0] d, input int code = -1);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        events = '0;
        if (code >= 0) events[code] = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_valid = 1'b0; bus_write = 1'b0; events = '0;
        end
    endtask

    task automatic pulse(input int code, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_valid = 1'b0; bus_write = 1'b0; events = '0; events[code] = 1'b1;
        end
    endtask

    task automatic pulse_all(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_valid = 1'b0; bus_write = 1'b0; events = '1;
        end
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input logic [31:0] elg, input int req);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0; events = '0;
        sbq.push_back('{1'b0, 8'(req), a, e, elg});
    endtask

    task automatic expect_irq(input bit e, input bit elg, input int req);
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; events = '0;
        sbq.push_back('{1'b1, 8'(req), 8'hFF, {31'd0, e}, {31'd0, elg}});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_rd(8'h00, 32'h2, 32'h2, 1);
        expect_rd(8'h04, 32'h2, 32'h2, 1);
        expect_rd(8'h20, 32'h0, 32'h0, 1);
        expect_irq(1'b0, 1'b0, 1);
        // R2 unmapped offsets read zero
        expect_rd(8'h14, 32'h0, 32'h0, 2);
        expect_rd(8'h30, 32'h0, 32'h0, 2);

        // R2 field layout read-back; R5 nothing counts while cycle slot is off
        op_wr(8'h04, ctl(5, 8'hAB, 1, 1, 0));
        expect_rd(8'h04, 32'h05AB0006, 32'h05AB0006, 2);
        pulse(5, 3);
        expect_rd(8'h24, 32'd0, 32'd0, 5);

        // R3 cycle slot start, code forced to zero, one step per cycle
        op_wr(8'h00, 32'h0);
        op_wr(8'h00, ctl(7, 0, 1, 1, 0));
        expect_rd(8'h00, 32'h00000006, 32'h00000006, 3);
        expect_rd(8'h20, 32'd1, 32'd1, 3);
        idle(5);
        expect_rd(8'h20, 32'd7, 32'd7, 3);

        // R4 matching code counts, other codes do not
        pulse(5, 4);
        expect_rd(8'h24, 32'd4, 32'd4, 4);
        pulse(6, 3);
        expect_rd(8'h24, 32'd4, 32'd4, 4);
        // R4 code beyond the event vector never matches
        op_wr(8'h08, ctl(8'h30, 0, 1, 1, 0));
        pulse_all(3);
        expect_rd(8'h28, 32'd0, 32'd0, 4);
        expect_rd(8'h24, 32'd7, 32'd7, 4);

        // R6 disable with clear=1 holds the count
        op_wr(8'h04, ctl(5, 0, 0, 1, 0));
        pulse(5, 3);
        expect_rd(8'h24, 32'd7, 32'd7, 6);
        op_wr(8'h04, ctl(5, 0, 1, 1, 0));
        pulse(5, 2);
        expect_rd(8'h24, 32'd9, 32'd9, 6);

        // R5 cycle slot disabled freezes bank, re-enable resumes
        op_wr(8'h00, 32'h0);
        op_wr(8'h00, ctl(0, 0, 1, 1, 0));
        idle(3);
        op_wr(8'h00, ctl(0, 0, 0, 1, 0));
        pulse(5, 3);
        expect_rd(8'h20, 32'd4, 32'd4, 5);
        expect_rd(8'h24, 32'd9, 32'd9, 5);
        op_wr(8'h00, ctl(0, 0, 1, 1, 0));
        pulse(5, 2);
        expect_rd(8'h24, 32'd11, 32'd11, 5);
        expect_rd(8'h20, 32'd7, 32'd7, 5);

        // R7 event clear, bit self-returns after one cycle
        op_wr(8'h04, ctl(5, 0, 1, 0, 0));
        expect_rd(8'h04, 32'h05000004, 32'h05000004, 7);
        expect_rd(8'h04, 32'h05000006, 32'h05000006, 7);
        expect_rd(8'h24, 32'd0, 32'd0, 7);

        // R13 clear and pulse in the same cycle: clear wins
        pulse(5, 2);
        expect_rd(8'h24, 32'd2, 32'd2, 13);
        op_wr(8'h04, ctl(5, 0, 1, 0, 0), 5);
        expect_rd(8'h24, 32'd0, 32'd0, 13);
        pulse(5, 1);
        expect_rd(8'h24, 32'd1, 32'd1, 13);

        // R8 cycle clear needs a rising clear bit and loads the preload
        op_wr(8'h00, 32'h0);
        op_wr(8'h00, ctl(0, 0, 1, 1, 0));
        idle(2);
        op_wr(8'h00, ctl(0, 0, 1, 0, 0));
        expect_rd(8'h20, 32'd3, 32'd3, 8);
        op_wr(8'h00, ctl(0, 8'h12, 1, 1, 0));
        expect_rd(8'h20, 32'h120, 32'h120, 8);
        expect_rd(8'h00, 32'h00120006, 32'h00120006, 8);

        // R9 cycle wrap freezes bank and raises irq
        op_wr(8'h08, ctl(3, 0, 1, 1, 0));
        op_wr(8'h00, 32'h0);
        op_wr(8'h00, ctl(0, 8'hF0, 1, 1, 0));
        idle(250);
        expect_rd(8'h20, 32'hFFA, 32'hFFA, 8);
        idle(4);
        expect_rd(8'h20, 32'hFFF, 32'hFFF, 9);
        expect_irq(1'b1, 1'b1, 9);
        expect_rd(8'h00, 32'h00F00007, 32'h00F00007, 9);
        expect_rd(8'h20, 32'd0, 32'd0, 9);
        pulse(3, 5);
        expect_rd(8'h28, 32'd0, 32'd0, 9);
        idle(10);
        expect_rd(8'h20, 32'd0, 32'd0, 9);
        // R10 irq held until the full clear sequence
        expect_irq(1'b1, 1'b1, 10);
        op_wr(8'h00, ctl(0, 0, 1, 0, 0));
        expect_irq(1'b1, 1'b1, 10);
        op_wr(8'h00, ctl(0, 0, 1, 1, 0));
        expect_irq(1'b0, 1'b0, 10);
        pulse(3, 2);
        expect_rd(8'h28, 32'd2, 32'd2, 10);

        // R11 / R12 event slot wrap, stop versus keep counting
        op_wr(8'h04, ctl(5, 0, 1, 0, 0));
        pulse(5, 2000);
        op_wr(8'h00, 32'h0);
        op_wr(8'h00, ctl(0, 0, 1, 1, 0));
        pulse(5, 2000);
        pulse(5, 95);
        expect_rd(8'h24, 32'hFFF, 32'hFFF, 11);
        pulse(5, 1);
        expect_rd(8'h24, 32'd0, 32'd0, 11);
        expect_rd(8'h04, 32'h05000007, 32'h05000007, 11);
        expect_irq(1'b0, 1'b0, 11);
        pulse(5, 10);
        expect_rd(8'h24, 32'd0, 32'd10, 11);
        expect_rd(8'h24, 32'd0, 32'd10, 12);
        // R7 clearing an overflowed event slot restarts it
        op_wr(8'h04, ctl(5, 0, 1, 0, 0));
        pulse(5, 3);
        expect_rd(8'h24, 32'd3, 32'd3, 7);
        expect_rd(8'h04, 32'h05000006, 32'h05000006, 7);

        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule